// File: doc/BRIEF.md
# Banked Translation Base Register Access Controller

This block owns one 64-bit translation base register that exists in up to three copies: a common copy, a secure copy and a non-secure copy. Each cycle it may receive one coprocessor-style access request. The request carries the requesting exception level, a read/write flag, a narrow/wide flag, the encoding fields and the write data. The block decides in the same cycle whether the request completes, traps to the hypervisor level or is undefined. A completed write commits on the next clock edge.

The decision follows a fixed order. Undefined conditions are checked first. Next come the hypervisor trap enables, which only act on requests from the kernel level while the hypervisor level is enabled. Last, the block picks the copy to access from the security state and the level. A narrow access moves only the low 32 bits of the register. A wide access moves all 64 bits as a register pair. Field meaning, table walks and exception entry are left to neighbouring logic.

Top module: `tbase_bank_ctrl`

## Requirements
- R1: A request is claimed only in two cases. The narrow form needs `req_wide`=0 with coproc=15, opc1=0, CRn=2, CRm=0, opc2=1. The wide form needs `req_wide`=1 with coproc=15, opc1=1, CRm=2, and CRn and opc2 are ignored. An unclaimed or invalid request raises no outcome flag and changes no copy.
- R2: With `cfg_a32_el1`=0, every claimed request is undefined, at every level, whatever the trap enables are.
- R3: A claimed request from level 0 (`req_el`=0) is undefined, whatever the trap enables are.
- R4: At level 1 with `cfg_el2_en`=1, `ctl_trap_all`=1 traps both reads and writes. Requests at level 2 or 3, or with `cfg_el2_en`=0, are never trapped.
- R5: At level 1 with `cfg_el2_en`=1, `ctl_trap_rd` traps reads only and `ctl_trap_wr` traps writes only. They are checked in the order all, read, write.
- R6: On a trap, `rsp_trap_a64` equals `cfg_el2_a64` and `rsp_syndrome` is 0x03 for a narrow access or 0x04 for a wide access. Both are zero when there is no trap.
- R7: An untrapped request at level 1 or 2 uses the non-secure copy when `cfg_el3_a32`=1 and the common copy otherwise.
- R8: A request at level 3 uses the secure copy when `ctl_ns`=0 and the non-secure copy when `ctl_ns`=1.
- R9: At level 3 with `ctl_ns`=0 and `ctl_sec_lock`=1, a write is undefined and leaves every copy unchanged. Reads are unaffected.
- R10: A completed narrow write replaces bits [31:0] of the selected copy and keeps bits [63:32]. A narrow read returns bits [31:0], with bits [63:32] of `rsp_rdata` zero.
- R11: A completed wide write replaces all 64 bits, and a wide read returns all 64 bits. `rsp_rdata` is zero except for a completed read.
- R12: For each valid claimed request, exactly one of `rsp_done`, `rsp_undef` and `rsp_trap` is high, in the request's own cycle. A write commits only when `rsp_done` is high.
- R13: After a synchronous active-low reset, all copies read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_el | input | 2 | Requesting exception level 0..3 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit pair access, 0 = 32-bit access |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 4 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 64 | Write data (low half used by narrow writes) |
| cfg_a32_el1 | input | 1 | 32-bit kernel level implemented |
| cfg_el2_en | input | 1 | Hypervisor level enabled |
| cfg_el2_a64 | input | 1 | Hypervisor level runs in 64-bit state |
| cfg_el3_a32 | input | 1 | 32-bit monitor level implemented (banked copies in use) |
| ctl_trap_all | input | 1 | Trap all kernel-level accesses |
| ctl_trap_rd | input | 1 | Trap kernel-level reads |
| ctl_trap_wr | input | 1 | Trap kernel-level writes |
| ctl_ns | input | 1 | Non-secure state bit |
| ctl_sec_lock | input | 1 | Lock secure writes at monitor level |
| rsp_rdata | output | 64 | Read data |
| rsp_done | output | 1 | Request completed |
| rsp_undef | output | 1 | Request undefined |
| rsp_trap | output | 1 | Request trapped to hypervisor level |
| rsp_trap_a64 | output | 1 | Trap taken as a 64-bit-state trap |
| rsp_syndrome | output | 6 | Trap syndrome code |

## Verification
An undefined condition and a trap condition can both be true in the same cycle. The bench sets every trap enable while issuing from level 0, or with the 32-bit kernel level absent. The scoreboard then expects only the undefined flag, with no syndrome. A write that is undefined or trapped, and a later read of the same copy, are also paired: the read result shows that the copy held its old value.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
  localparam int REG_W     = 64;
  localparam int HALF_W    = REG_W / 2;
  localparam int SYN_W     = 6;
  localparam int FLD_W     = 4;
  localparam int OP2_W     = 3;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  localparam logic [SYN_W-1:0] SYN_NARROW = 6'h03;
  localparam logic [SYN_W-1:0] SYN_WIDE   = 6'h04;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  typedef enum logic [BANK_W-1:0] {
    BANK_COMMON = 2'd0,
    BANK_SEC    = 2'd1,
    BANK_NSEC   = 2'd2
  } bank_e;

  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_DONE  = 2'd1,
    VERD_UNDEF = 2'd2,
    VERD_TRAP  = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ALL  = 2'd1,
    CAUSE_RD   = 2'd2,
    CAUSE_WR   = 2'd3
  } cause_e;

  // Copy selection: monitor level follows the state bit, lower levels
  // use the non-secure copy only when banking is present.
  function automatic bank_e pick_bank(input level_e el, input logic ns,
                                      input logic banked);
    if (el == LVL_MON) return ns ? BANK_NSEC : BANK_SEC;
    return banked ? BANK_NSEC : BANK_COMMON;
  endfunction

  function automatic logic [SYN_W-1:0] syn_code(input logic wide);
    return wide ? SYN_WIDE : SYN_NARROW;
  endfunction
endpackage

// File: rtl/tbase_enc_match.sv
`timescale 1ns/1ps
module tbase_enc_match #(
  parameter int              FLD_W  = 4,
  parameter int              OP2_W  = 3,
  parameter logic [FLD_W-1:0] CP_ID  = 4'd15,
  parameter logic [FLD_W-1:0] N_OPC1 = 4'd0,
  parameter logic [FLD_W-1:0] N_CRN  = 4'd2,
  parameter logic [FLD_W-1:0] N_CRM  = 4'd0,
  parameter logic [OP2_W-1:0] N_OPC2 = 3'd1,
  parameter logic [FLD_W-1:0] W_OPC1 = 4'd1,
  parameter logic [FLD_W-1:0] W_CRM  = 4'd2
) (
  input  logic [FLD_W-1:0] coproc,
  input  logic [FLD_W-1:0] opc1,
  input  logic [FLD_W-1:0] crn,
  input  logic [FLD_W-1:0] crm,
  input  logic [OP2_W-1:0] opc2,
  input  logic             wide,
  output logic             hit,
  output logic             hit_wide
);
  logic cp_ok;
  logic narrow_ok;
  logic wide_ok;

  assign cp_ok     = (coproc == CP_ID);
  assign narrow_ok = !wide && cp_ok && (opc1 == N_OPC1) && (crn == N_CRN)
                     && (crm == N_CRM) && (opc2 == N_OPC2);
  assign wide_ok   = wide && cp_ok && (opc1 == W_OPC1) && (crm == W_CRM);

  assign hit      = narrow_ok || wide_ok;
  assign hit_wide = wide_ok;
endmodule

// File: rtl/tbase_policy.sv
`timescale 1ns/1ps
module tbase_policy
  import tbase_pkg::*;
#(
  parameter int SYN_W  = tbase_pkg::SYN_W,
  parameter int BANK_W = tbase_pkg::BANK_W
) (
  input  logic              valid,
  input  logic              hit,
  input  logic [1:0]        el,
  input  logic              write,
  input  logic              wide,
  input  logic              cfg_a32_el1,
  input  logic              cfg_el2_en,
  input  logic              cfg_el2_a64,
  input  logic              cfg_el3_a32,
  input  logic              ctl_trap_all,
  input  logic              ctl_trap_rd,
  input  logic              ctl_trap_wr,
  input  logic              ctl_ns,
  input  logic              ctl_sec_lock,
  output verdict_e          verdict,
  output logic              trap_a64,
  output logic [SYN_W-1:0]  syndrome,
  output logic [BANK_W-1:0] bank_sel,
  output logic              commit
);
  level_e lvl;
  cause_e cause;
  logic   ev_feat_off;
  logic   ev_user;
  logic   ev_sec_lock;
  logic   ev_undef;
  logic   ev_trap;
  logic   trap_window;

  assign lvl         = level_e'(el);
  assign ev_feat_off = !cfg_a32_el1;
  assign ev_user     = (lvl == LVL_USER);
  assign ev_sec_lock = (lvl == LVL_MON) && !ctl_ns && ctl_sec_lock && write;
  assign ev_undef    = ev_feat_off || ev_user || ev_sec_lock;
  assign trap_window = (lvl == LVL_KERNEL) && cfg_el2_en;

  // Fixed priority: all-access enable, then read enable, then write enable.
  always_comb begin
    cause = CAUSE_NONE;
    if (trap_window) begin
      if (ctl_trap_all)               cause = CAUSE_ALL;
      else if (!write && ctl_trap_rd) cause = CAUSE_RD;
      else if (write && ctl_trap_wr)  cause = CAUSE_WR;
    end
  end

  assign ev_trap = (cause != CAUSE_NONE);

  always_comb begin
    verdict = VERD_NONE;
    if (valid && hit) begin
      if (ev_undef)     verdict = VERD_UNDEF;
      else if (ev_trap) verdict = VERD_TRAP;
      else              verdict = VERD_DONE;
    end
  end

  assign trap_a64 = (verdict == VERD_TRAP) && cfg_el2_a64;
  assign syndrome = (verdict == VERD_TRAP) ? syn_code(wide) : '0;
  assign bank_sel = BANK_W'(pick_bank(lvl, ctl_ns, cfg_el3_a32));
  assign commit   = (verdict == VERD_DONE) && write;
endmodule

// File: rtl/tbase_bank_store.sv
`timescale 1ns/1ps
module tbase_bank_store #(
  parameter int REG_W     = 64,
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             wide,
  input  logic [BANK_W-1:0]                sel,
  input  logic [REG_W-1:0]                 wdata,
  output logic [REG_W-1:0]                 rd_data,
  output logic [NUM_BANKS-1:0][REG_W-1:0]  banks
);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0] cur;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_b;
      assign hit_b = wr_en && (sel == BANK_W'(b));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          banks[b] <= '0;
        end else if (hit_b) begin
          if (wide) banks[b] <= wdata;
          else      banks[b] <= {banks[b][REG_W-1:HALF_W], wdata[HALF_W-1:0]};
        end
      end
    end
  endgenerate

  always_comb begin
    cur = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel == BANK_W'(b)) cur = banks[b];
    end
  end

  assign rd_data = wide ? cur : {{HALF_W{1'b0}}, cur[HALF_W-1:0]};
endmodule

// File: rtl/tbase_bank_ctrl.sv
`timescale 1ns/1ps
module tbase_bank_ctrl
  import tbase_pkg::*;
#(
  parameter logic [3:0] CP_ID  = 4'd15,
  parameter logic [3:0] N_OPC1 = 4'd0,
  parameter logic [3:0] N_CRN  = 4'd2,
  parameter logic [3:0] N_CRM  = 4'd0,
  parameter logic [2:0] N_OPC2 = 3'd1,
  parameter logic [3:0] W_OPC1 = 4'd1,
  parameter logic [3:0] W_CRM  = 4'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_el,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [3:0]  req_coproc,
  input  logic [3:0]  req_opc1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_opc2,
  input  logic [63:0] req_wdata,
  input  logic        cfg_a32_el1,
  input  logic        cfg_el2_en,
  input  logic        cfg_el2_a64,
  input  logic        cfg_el3_a32,
  input  logic        ctl_trap_all,
  input  logic        ctl_trap_rd,
  input  logic        ctl_trap_wr,
  input  logic        ctl_ns,
  input  logic        ctl_sec_lock,
  output logic [63:0] rsp_rdata,
  output logic        rsp_done,
  output logic        rsp_undef,
  output logic        rsp_trap,
  output logic        rsp_trap_a64,
  output logic [5:0]  rsp_syndrome
);
  logic                            claim_hit;
  logic                            claim_wide;
  verdict_e                        verdict;
  logic                            commit;
  logic [BANK_W-1:0]               bank_sel;
  logic [REG_W-1:0]                rd_raw;
  logic [NUM_BANKS-1:0][REG_W-1:0] bank_q;

  tbase_enc_match #(
    .FLD_W(FLD_W), .OP2_W(OP2_W), .CP_ID(CP_ID),
    .N_OPC1(N_OPC1), .N_CRN(N_CRN), .N_CRM(N_CRM), .N_OPC2(N_OPC2),
    .W_OPC1(W_OPC1), .W_CRM(W_CRM)
  ) u_match (
    .coproc  (req_coproc),
    .opc1    (req_opc1),
    .crn     (req_crn),
    .crm     (req_crm),
    .opc2    (req_opc2),
    .wide    (req_wide),
    .hit     (claim_hit),
    .hit_wide(claim_wide)
  );

  tbase_policy #(.SYN_W(SYN_W), .BANK_W(BANK_W)) u_policy (
    .valid       (req_valid),
    .hit         (claim_hit),
    .el          (req_el),
    .write       (req_write),
    .wide        (claim_wide),
    .cfg_a32_el1 (cfg_a32_el1),
    .cfg_el2_en  (cfg_el2_en),
    .cfg_el2_a64 (cfg_el2_a64),
    .cfg_el3_a32 (cfg_el3_a32),
    .ctl_trap_all(ctl_trap_all),
    .ctl_trap_rd (ctl_trap_rd),
    .ctl_trap_wr (ctl_trap_wr),
    .ctl_ns      (ctl_ns),
    .ctl_sec_lock(ctl_sec_lock),
    .verdict     (verdict),
    .trap_a64    (rsp_trap_a64),
    .syndrome    (rsp_syndrome),
    .bank_sel    (bank_sel),
    .commit      (commit)
  );

  tbase_bank_store #(.REG_W(REG_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (commit),
    .wide   (req_wide),
    .sel    (bank_sel),
    .wdata  (req_wdata),
    .rd_data(rd_raw),
    .banks  (bank_q)
  );

  assign rsp_done  = (verdict == VERD_DONE);
  assign rsp_undef = (verdict == VERD_UNDEF);
  assign rsp_trap  = (verdict == VERD_TRAP);
  assign rsp_rdata = (rsp_done && !req_write) ? rd_raw : '0;
endmodule

// File: rtl/tbase_bank_chk.sv
`timescale 1ns/1ps
module tbase_bank_chk
  import tbase_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic [1:0]                      req_el,
  input logic                            req_write,
  input logic                            req_wide,
  input logic                            cfg_a32_el1,
  input logic                            cfg_el2_a64,
  input logic                            ctl_ns,
  input logic                            ctl_sec_lock,
  input logic                            claim_hit,
  input logic [BANK_W-1:0]               bank_sel,
  input logic [NUM_BANKS-1:0][REG_W-1:0] bank_q,
  input logic                            rsp_done,
  input logic                            rsp_undef,
  input logic                            rsp_trap,
  input logic                            rsp_trap_a64,
  input logic [5:0]                      rsp_syndrome
);
  logic              last_nw;
  logic [BANK_W-1:0] last_sel;
  logic [HALF_W-1:0] last_hi;
  logic [HALF_W-1:0] sel_hi;
  logic [HALF_W-1:0] prev_sel_hi;
  logic              live;

  assign live = req_valid && claim_hit;

  always_comb begin
    sel_hi      = '0;
    prev_sel_hi = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BANK_W'(b)) sel_hi      = bank_q[b][REG_W-1:HALF_W];
      if (last_sel == BANK_W'(b)) prev_sel_hi = bank_q[b][REG_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_nw  <= 1'b0;
      last_sel <= '0;
      last_hi  <= '0;
    end else begin
      last_nw  <= rsp_done && req_write && !req_wide;
      last_sel <= bank_sel;
      last_hi  <= sel_hi;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $countones({rsp_done, rsp_undef, rsp_trap}) == 1); // R12
  AST_QUIET_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !rsp_done && !rsp_undef && !rsp_trap); // R1
  AST_FEATURE_OFF_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    live && !cfg_a32_el1 |-> rsp_undef); // R2
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    live && req_el == 2'd0 |-> rsp_undef); // R3
  AST_TRAP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_trap_a64 == cfg_el2_a64
                 && rsp_syndrome == (req_wide ? 6'h04 : 6'h03)); // R6
  AST_SEC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    live && cfg_a32_el1 && req_el == 2'd3 && !ctl_ns && ctl_sec_lock && req_write
    |-> rsp_undef); // R9
  AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_undef || rsp_trap) |=> bank_q == $past(bank_q)); // R12
  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    last_nw |-> prev_sel_hi == last_hi); // R10
endmodule

bind tbase_bank_ctrl tbase_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_el(req_el),
  .req_write(req_write), .req_wide(req_wide), .cfg_a32_el1(cfg_a32_el1),
  .cfg_el2_a64(cfg_el2_a64), .ctl_ns(ctl_ns), .ctl_sec_lock(ctl_sec_lock),
  .claim_hit(claim_hit), .bank_sel(bank_sel), .bank_q(bank_q),
  .rsp_done(rsp_done), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
  .rsp_trap_a64(rsp_trap_a64), .rsp_syndrome(rsp_syndrome)
);

// File: tb/tbase_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module tbase_bank_ctrl_tb_top;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_el = 2'd0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [3:0]  req_coproc = 4'd0;
  logic [3:0]  req_opc1 = 4'd0;
  logic [3:0]  req_crn = 4'd0;
  logic [3:0]  req_crm = 4'd0;
  logic [2:0]  req_opc2 = 3'd0;
  logic [63:0] req_wdata = 64'd0;
  logic        cfg_a32_el1 = 1'b1;
  logic        cfg_el2_en = 1'b0;
  logic        cfg_el2_a64 = 1'b0;
  logic        cfg_el3_a32 = 1'b0;
  logic        ctl_trap_all = 1'b0;
  logic        ctl_trap_rd = 1'b0;
  logic        ctl_trap_wr = 1'b0;
  logic        ctl_ns = 1'b0;
  logic        ctl_sec_lock = 1'b0;
  logic [63:0] rsp_rdata;
  logic        rsp_done;
  logic        rsp_undef;
  logic        rsp_trap;
  logic        rsp_trap_a64;
  logic [5:0]  rsp_syndrome;

  always #5 clk = ~clk;

  tbase_bank_ctrl dut_i (.*);

  typedef struct {
    string       tag;
    bit          done;
    bit          undef;
    bit          trap;
    bit          a64;
    logic [5:0]  syn;
    logic [63:0] rdata;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] model [3];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 0;

  // Driver: applies one request cycle and pushes the expected outcome.
  task automatic issue(input string tag, input bit v, input logic [1:0] el,
                       input bit wr, input bit wide, input bit bad,
                       input logic [63:0] wd);
    exp_t e;
    int   b;
    @(negedge clk);
    #1;
    req_valid = v; req_el = el; req_write = wr; req_wide = wide; req_wdata = wd;
    req_coproc = 4'd15;
    if (wide) begin
      req_opc1 = 4'd1; req_crn = 4'd7; req_crm = bad ? 4'd3 : 4'd2; req_opc2 = 3'd5;
    end else begin
      req_opc1 = 4'd0; req_crn = bad ? 4'd3 : 4'd2; req_crm = 4'd0; req_opc2 = 3'd1;
    end
    e = '{tag, 0, 0, 0, 0, 6'd0, 64'd0};
    if (v && !bad) begin
      if (!cfg_a32_el1 || el == 2'd0 || (el == 2'd3 && !ctl_ns && ctl_sec_lock && wr)) begin
        e.undef = 1;
      end else if (el == 2'd1 && cfg_el2_en &&
                   (ctl_trap_all || (wr ? ctl_trap_wr : ctl_trap_rd))) begin
        e.trap = 1; e.a64 = cfg_el2_a64; e.syn = wide ? 6'h04 : 6'h03;
      end else begin
        e.done = 1;
        if (el == 2'd3) b = ctl_ns ? 2 : 1;
        else            b = cfg_el3_a32 ? 2 : 0;
        if (wr) begin
          if (wide) model[b] = wd;
          else      model[b][31:0] = wd[31:0];
        end else begin
          e.rdata = wide ? model[b] : {32'd0, model[b][31:0]};
        end
      end
    end
    sb_q.push_back(e);
    #5;
    req_valid = 1'b0;
  endtask

  // Monitor: samples between edges and compares against the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (rsp_done !== e.done || rsp_undef !== e.undef || rsp_trap !== e.trap ||
            rsp_trap_a64 !== e.a64 || rsp_syndrome !== e.syn || rsp_rdata !== e.rdata) begin
          n_errors++;
          $display("FAIL %s: got done=%0b undef=%0b trap=%0b a64=%0b syn=%h rdata=%h, expected done=%0b undef=%0b trap=%0b a64=%0b syn=%h rdata=%h",
                   e.tag, rsp_done, rsp_undef, rsp_trap, rsp_trap_a64, rsp_syndrome, rsp_rdata,
                   e.done, e.undef, e.trap, e.a64, e.syn, e.rdata);
        end
      end
    end
  end

  initial begin
    #(WD_CYCLES * 10);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got no end, expected end within %0d cycles", WD_CYCLES);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13: every copy is zero after reset
    issue("R13", 1, 2'd1, 0, 1, 0, 64'd0);
    cfg_el3_a32 = 1;
    ctl_ns = 0; issue("R13", 1, 2'd3, 0, 1, 0, 64'd0);
    ctl_ns = 1; issue("R13", 1, 2'd3, 0, 1, 0, 64'd0);
    issue("R13", 1, 2'd1, 0, 1, 0, 64'd0);
    cfg_el3_a32 = 0; ctl_ns = 0;

    // R11 / R7: wide write and read of the common copy
    issue("R11", 1, 2'd1, 1, 1, 0, 64'h0123_4567_89AB_CDEF);
    issue("R11", 1, 2'd1, 0, 1, 0, 64'd0);
    // R10: narrow write keeps the upper half, narrow read zero-extends
    issue("R10", 1, 2'd1, 1, 0, 0, 64'hFFFF_FFFF_1122_3344);
    issue("R10", 1, 2'd1, 0, 1, 0, 64'd0);
    issue("R10", 1, 2'd1, 0, 0, 0, 64'd0);

    // R7 / R8: banked copies
    cfg_el3_a32 = 1;
    issue("R7", 1, 2'd2, 1, 1, 0, 64'hA5A5_A5A5_A5A5_A5A5);
    ctl_ns = 1; issue("R8", 1, 2'd3, 0, 1, 0, 64'd0);
    ctl_ns = 0; issue("R8", 1, 2'd3, 0, 1, 0, 64'd0);
    issue("R8", 1, 2'd3, 1, 1, 0, 64'h5A5A_0000_5A5A_1111);
    issue("R8", 1, 2'd3, 0, 1, 0, 64'd0);
    issue("R7", 1, 2'd1, 0, 1, 0, 64'd0);
    cfg_el3_a32 = 0;
    issue("R7", 1, 2'd1, 0, 1, 0, 64'd0);

    // R3: level 0 is undefined and changes nothing
    issue("R3", 1, 2'd0, 1, 1, 0, 64'hDEAD_BEEF_DEAD_BEEF);
    issue("R3", 1, 2'd0, 0, 0, 0, 64'd0);
    issue("R3", 1, 2'd1, 0, 1, 0, 64'd0);

    // R2: feature absent
    cfg_a32_el1 = 0;
    issue("R2", 1, 2'd1, 0, 1, 0, 64'd0);
    issue("R2", 1, 2'd1, 1, 0, 0, 64'h1);
    issue("R2", 1, 2'd3, 0, 1, 0, 64'd0);
    cfg_a32_el1 = 1;

    // R4 / R6: trap-all enable
    cfg_el2_en = 1; ctl_trap_all = 1;
    issue("R4", 1, 2'd1, 0, 0, 0, 64'd0);
    cfg_el2_a64 = 1;
    issue("R6", 1, 2'd1, 1, 1, 0, 64'h7777_7777_7777_7777);
    issue("R4", 1, 2'd2, 0, 1, 0, 64'd0);
    issue("R4", 1, 2'd2, 1, 0, 0, 64'h0000_0000_CAFE_F00D);
    cfg_el2_en = 0;
    issue("R4", 1, 2'd1, 0, 1, 0, 64'd0);
    cfg_el2_en = 1;

    // Overlap of undefined and trap conditions: undefined wins
    ctl_trap_rd = 1; ctl_trap_wr = 1;
    issue("R3", 1, 2'd0, 1, 1, 0, 64'h1234);
    cfg_a32_el1 = 0;
    issue("R2", 1, 2'd1, 0, 0, 0, 64'd0);
    cfg_a32_el1 = 1;
    ctl_trap_all = 0; ctl_trap_rd = 0; ctl_trap_wr = 0;

    // R5: read-only and write-only trap enables
    cfg_el2_a64 = 0; ctl_trap_rd = 1;
    issue("R5", 1, 2'd1, 0, 1, 0, 64'd0);
    issue("R5", 1, 2'd1, 1, 0, 0, 64'h0000_0000_ABCD_0001);
    ctl_trap_rd = 0; ctl_trap_wr = 1;
    issue("R5", 1, 2'd1, 1, 1, 0, 64'hFFFF_0000_FFFF_0000);
    issue("R5", 1, 2'd1, 0, 1, 0, 64'd0);
    ctl_trap_wr = 0; cfg_el2_en = 0;

    // R9: secure write lock at level 3
    cfg_el3_a32 = 1; ctl_ns = 0; ctl_sec_lock = 1;
    issue("R9", 1, 2'd3, 1, 1, 0, 64'hBAD0_BAD0_BAD0_BAD0);
    issue("R9", 1, 2'd3, 1, 0, 0, 64'h0000_0000_BAD1_BAD1);
    issue("R9", 1, 2'd3, 0, 1, 0, 64'd0);
    ctl_ns = 1;
    issue("R9", 1, 2'd3, 1, 0, 0, 64'h0000_0000_0600_0D00);
    issue("R9", 1, 2'd3, 0, 1, 0, 64'd0);
    ctl_sec_lock = 0; ctl_ns = 0; cfg_el3_a32 = 0;

    // R1: unclaimed encodings and invalid cycles are ignored
    issue("R1", 1, 2'd1, 1, 1, 1, 64'h9999_9999_9999_9999);
    issue("R1", 1, 2'd1, 1, 0, 1, 64'h0000_0000_9999_9999);
    issue("R1", 0, 2'd1, 1, 1, 0, 64'h8888_8888_8888_8888);
    issue("R1", 1, 2'd1, 0, 1, 0, 64'd0);

    // R12: back-to-back writes then a read
    issue("R12", 1, 2'd1, 1, 1, 0, 64'h1111_2222_3333_4444);
    issue("R12", 1, 2'd1, 1, 0, 0, 64'h0000_0000_5555_6666);
    issue("R12", 1, 2'd1, 0, 1, 0, 64'd0);

    @(negedge clk);
    @(negedge clk);
    wait (sb_q.size() == 0);
    #5;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule